// File: doc/BRIEF.md
# Configurable Barrel Shifter

This block moves a data word left or right by a run-time amount. It has three kinds of shift: a left shift, a right shift that always brings in zeros, and a right shift that can copy the top bit into the freed positions. A separate signed-mode input decides whether that last kind copies the top bit. When signed mode is off, it behaves exactly like the zero-filling right shift. The output word is always as wide as the input word. Bits pushed past either end are dropped, and the block produces no carry, overflow or wider result.

The shift-amount input is wider than the number of bits needed to index the word. Any amount at or above the word width saturates the result. For the left shift, the zero-filling right shift and the unsigned copy-fill right shift, the result is all zeros. For the signed copy-fill right shift, the result is every bit equal to the input's top bit. Internally, the shifter is a tree of log2(WIDTH) multiplexer stages. A parameter can add one output register stage, which delays the result by one clock and qualifies it with a valid bit.

Top module: `bshift_unit`

## Requirements
- R1: Operation codes 2'b00 and 2'b01 both shift left. They give identical results, and the vacated low bits are filled with zeros.
- R2: Operation code 2'b10 shifts right and fills the vacated high bits with zeros, whatever the value of `signed_mode`.
- R3: Operation code 2'b11 with `signed_mode`=1 shifts right and fills with copies of bit WIDTH-1. This is floor division by 2^amt: 16'hFFF9 (-7) shifted by 2 gives 16'hFFFE (-2).
- R4: Operation code 2'b11 with `signed_mode`=0 fills with zeros, so it gives the same result as code 2'b10.
- R5: `amt` is read as an unsigned number. When `amt` is WIDTH or larger, codes 2'b00, 2'b01 and 2'b10, and code 2'b11 with `signed_mode`=0, give all zeros. This holds even when the low log2(WIDTH) bits of `amt` are zero.
- R6: Code 2'b11 with `signed_mode`=1 and `amt` of WIDTH or larger gives all ones if bit WIDTH-1 of the input is 1, and all zeros otherwise.
- R7: The result has exactly WIDTH bits, and bits shifted past an edge are lost. For example, 16'hC000 shifted left by 2 gives 16'h0000.
- R8: An `amt` of zero returns the input word unchanged, for every operation code.
- R9: With REGISTER_OUT=1, the result and `out_valid` appear one clock after the inputs. `out_valid` is the previous cycle's `in_valid`. A synchronous active-low reset clears `out_valid` and `data_out` to zero, even while `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the inputs of this cycle as a request |
| data_in | input | WIDTH | Word to be shifted |
| amt | input | AMT_W | Unsigned shift distance |
| op | input | 2 | Operation: 00/01 left, 10 right zero-fill, 11 right copy-fill |
| signed_mode | input | 1 | Treat `data_in` as signed for code 11 |
| out_valid | output | 1 | Marks `data_out` as a result |
| data_out | output | WIDTH | Shifted word, WIDTH bits |

## Verification
The hardest cases to reach are over-range amounts whose low index bits are all zero, such as WIDTH, 8×WIDTH or 128. To the multiplexer tree these look like no shift at all, so only the saturation path gives the right answer. The stimulus drives these amounts, along with the maximum amount and amounts just below and above WIDTH, under every operation code and both signed-mode settings. It uses negative, positive and single-bit data words, and a reference model computed bit by bit checks every response. Reset is also applied while a request is being presented, to show that the pending request is discarded.

// File: rtl/bshift_pkg.sv
// Package: shared operation encoding for the barrel shifter.
// Assumes: op is a 2-bit field; bit 1 separates left (0) from right (1).
package bshift_pkg;

    typedef enum logic [1:0] {
        OP_SHL     = 2'b00,
        OP_SHL_ALT = 2'b01,
        OP_SHR     = 2'b10,
        OP_SAR     = 2'b11
    } shift_op_e;

endpackage

// File: rtl/bshift_ctrl.sv
// Module: bshift_ctrl
// Decodes the operation into a direction and a fill bit. It also flags
// shift amounts that reach or pass the word width.
// Assumes: amt is unsigned, and AMT_W bits can hold a value of WIDTH.
module bshift_ctrl
    import bshift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AMT_W = 8
) (
    input  logic [1:0]       op,
    input  logic             signed_mode,
    input  logic             msb,
    input  logic [AMT_W-1:0] amt,
    output logic             go_right,
    output logic             fill_bit,
    output logic             over_range
);
    localparam logic [AMT_W:0] LIMIT = (AMT_W+1)'(WIDTH);

    // Direction, fill value and saturation detect
    always_comb begin
        go_right   = op[1];
        fill_bit   = (shift_op_e'(op) == OP_SAR) && signed_mode && msb;
        over_range = ({1'b0, amt} >= LIMIT);
    end
endmodule

// File: rtl/bshift_stage.sv
// Module: bshift_stage
// One level of the multiplexer tree. When sel is high, it moves the word
// by DIST places. Right moves bring in fill; left moves bring in zeros.
// Assumes: 0 < DIST < WIDTH.
module bshift_stage #(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] d_in,
    input  logic             sel,
    input  logic             go_right,
    input  logic             fill_bit,
    output logic [WIDTH-1:0] d_out
);
    logic [WIDTH-1:0] moved_r;
    logic [WIDTH-1:0] moved_l;

    // Both candidate moves are fixed wiring
    assign moved_r = {{DIST{fill_bit}}, d_in[WIDTH-1:DIST]};
    assign moved_l = {d_in[WIDTH-1-DIST:0], {DIST{1'b0}}};

    // Pick pass-through or the move in the requested direction
    always_comb begin
        if (!sel)          d_out = d_in;
        else if (go_right) d_out = moved_r;
        else               d_out = moved_l;
    end
endmodule

// File: rtl/bshift_outreg.sv
// Module: bshift_outreg
// Optional output stage. With REGISTER_OUT=1 it registers data and valid,
// using a synchronous active-low reset. With 0 it is a plain wire.
// Assumes: clk and rst_n are not used when REGISTER_OUT=0.
module bshift_outreg #(
    parameter int WIDTH        = 16,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_in,
    input  logic [WIDTH-1:0] d_in,
    output logic             v_out,
    output logic [WIDTH-1:0] d_out
);
    generate
        if (REGISTER_OUT) begin : g_reg
            // Capture result and valid; reset clears both
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_out <= 1'b0;
                    d_out <= '0;
                end else begin
                    v_out <= v_in;
                    d_out <= d_in;
                end
            end
        end else begin : g_wire
            assign v_out = v_in;
            assign d_out = d_in;
        end
    endgenerate
endmodule

// File: rtl/bshift_unit.sv
// Module: bshift_unit (top)
// Barrel shifter that performs left, logical right and arithmetic right
// shifts. Amounts of WIDTH or more saturate the result. The output can be
// registered.
// Assumes: WIDTH >= 2 and AMT_W > $clog2(WIDTH) - 1.
module bshift_unit #(
    parameter int WIDTH        = 16,
    parameter int AMT_W        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amt,
    input  logic [1:0]       op,
    input  logic             signed_mode,
    output logic             out_valid,
    output logic [WIDTH-1:0] data_out
);
    localparam int LVL = $clog2(WIDTH);

    logic             go_right;
    logic             fill_bit;
    logic             over_range;
    logic [WIDTH-1:0] chain [LVL+1];
    logic [WIDTH-1:0] comb_res;

    bshift_ctrl #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_ctrl (
        .op          (op),
        .signed_mode (signed_mode),
        .msb         (data_in[WIDTH-1]),
        .amt         (amt),
        .go_right    (go_right),
        .fill_bit    (fill_bit),
        .over_range  (over_range)
    );

    assign chain[0] = data_in;

    generate
        for (genvar k = 0; k < LVL; k++) begin : g_lvl
            bshift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
                .d_in     (chain[k]),
                .sel      (amt[k]),
                .go_right (go_right),
                .fill_bit (fill_bit),
                .d_out    (chain[k+1])
            );
        end
    endgenerate

    // Over-range amounts replace the tree output with the fill pattern
    always_comb begin
        comb_res = over_range ? {WIDTH{fill_bit}} : chain[LVL];
    end

    bshift_outreg #(.WIDTH(WIDTH), .REGISTER_OUT(REGISTER_OUT)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .v_in  (in_valid),
        .d_in  (comb_res),
        .v_out (out_valid),
        .d_out (data_out)
    );
endmodule

// File: rtl/bshift_chk.sv
// Module: bshift_chk
// Port-level properties of bshift_unit, attached to it with bind.
// Assumes: it watches only top-level ports.
module bshift_chk #(
    parameter int WIDTH        = 16,
    parameter int AMT_W        = 8,
    parameter bit REGISTER_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] amt,
    input logic [1:0]       op,
    input logic             signed_mode,
    input logic             out_valid,
    input logic [WIDTH-1:0] data_out
);
    localparam logic [AMT_W:0] BIG = (AMT_W+1)'(WIDTH);
    logic beyond;
    assign beyond = ({1'b0, amt} >= BIG);

    generate
        if (REGISTER_OUT) begin : g_seq
            AST_VALID_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
                in_valid |=> out_valid);                                   // R9
            AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                !in_valid |=> !out_valid);                                 // R9
            AST_LEFT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !op[1] && beyond) |=> (data_out == '0));      // R5
            AST_SIGN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 2'b11 && signed_mode && beyond)
                |=> (data_out == {WIDTH{$past(data_in[WIDTH-1])}}));       // R6
            AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && amt == '0) |=> (data_out == $past(data_in))); // R8
            AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 2'b10 && amt != '0) |=> !data_out[WIDTH-1]); // R2
            AST_SAR_SIGN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 2'b11 && signed_mode)
                |=> (data_out[WIDTH-1] == $past(data_in[WIDTH-1])));        // R3
        end else begin : g_comb
            AST_LEFT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && !op[1] && beyond) |-> (data_out == '0));      // R5
            AST_SIGN_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 2'b11 && signed_mode && beyond)
                |-> (data_out == {WIDTH{data_in[WIDTH-1]}}));              // R6
            AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && amt == '0) |-> (data_out == data_in));        // R8
            AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && op == 2'b10 && amt != '0) |-> !data_out[WIDTH-1]); // R2
        end
    endgenerate
endmodule

bind bshift_unit bshift_chk #(
    .WIDTH(WIDTH), .AMT_W(AMT_W), .REGISTER_OUT(REGISTER_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
    .amt(amt), .op(op), .signed_mode(signed_mode),
    .out_valid(out_valid), .data_out(data_out)
);

// File: tb/sim_bshift_unit.sv
`timescale 1ns/1ps
// Scoreboard bench for bshift_unit. A driver task queues expected
// results, and a monitor pops and compares them as out_valid rises.
module sim_bshift_unit;
    localparam int W  = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [AW-1:0] amt = '0;
    logic [1:0]    op = 2'b00;
    logic          signed_mode = 1'b0;
    logic          out_valid;
    logic [W-1:0]  data_out;

    typedef struct {
        logic [W-1:0] exp;
        string        req;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    bshift_unit #(.WIDTH(W), .AMT_W(AW), .REGISTER_OUT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .data_in(data_in),
        .amt(amt), .op(op), .signed_mode(signed_mode),
        .out_valid(out_valid), .data_out(data_out)
    );

    // Reference: computed bit by bit from the requirements
    function automatic logic [W-1:0] model(input logic [W-1:0] d, input int a,
                                           input logic [1:0] o, input logic sm);
        logic [W-1:0] r;
        logic         f;
        f = (o == 2'b11) && sm && d[W-1];
        for (int i = 0; i < W; i++) begin
            if (!o[1]) r[i] = (i - a >= 0) ? d[i - a] : 1'b0;
            else       r[i] = (i + a < W)  ? d[i + a] : f;
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] d, input int a, input logic [1:0] o,
                         input logic sm, input logic [W-1:0] exp, input string req);
        item_t it;
        @(negedge clk);
        data_in = d; amt = AW'(a); op = o; signed_mode = sm; in_valid = 1'b1;
        it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each valid result against the queue head
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && out_valid) begin
                if (q.size() == 0) begin
                    check("R9 unexpected out_valid", 1'b1, 1'b0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(it.req, data_out, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R9: reset discards a request presented during reset
        in_valid = 1'b1; data_in = 16'hFFFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset out_valid", W'(out_valid), '0);
        check("R9 reset data_out", data_out, '0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle out_valid", W'(out_valid), '0);

        // R1: both left encodings, zero fill
        drive(16'h0001, 4, 2'b00, 1'b0, 16'h0010, "R1 shl");
        drive(16'h0001, 4, 2'b01, 1'b1, 16'h0010, "R1 shl alt");
        drive(16'h1A2B, 1, 2'b01, 1'b0, 16'h3456, "R1 shl alt 1");
        // R7: bits pushed out are lost
        drive(16'hC000, 2, 2'b00, 1'b0, 16'h0000, "R7 lost top");
        drive(16'h00FF, 12, 2'b01, 1'b0, 16'hF000, "R7 truncate");
        // R2: logical right ignores signed mode
        drive(16'hFFF8, 2, 2'b10, 1'b1, 16'h3FFE, "R2 shr signed");
        // R3: signed arithmetic right floors
        drive(16'hFFF8, 2, 2'b11, 1'b1, 16'hFFFE, "R3 -8>>>2");
        drive(16'hFFF9, 2, 2'b11, 1'b1, 16'hFFFE, "R3 -7 floor");
        drive(16'h4000, 3, 2'b11, 1'b1, 16'h0800, "R3 positive");
        // R4: unsigned arithmetic right zero fills
        drive(16'hFFF8, 2, 2'b11, 1'b0, 16'h3FFE, "R4 unsigned sar");
        // R5: over-range saturates to zero
        drive(16'hFFFF, 16, 2'b00, 1'b0, 16'h0000, "R5 shl 16");
        drive(16'hFFFF, 200, 2'b10, 1'b1, 16'h0000, "R5 shr 200");
        drive(16'h8000, 16, 2'b11, 1'b0, 16'h0000, "R5 sar unsigned 16");
        drive(16'h1234, 128, 2'b01, 1'b0, 16'h0000, "R5 shl 128");
        drive(16'hFFFF, 32, 2'b10, 1'b0, 16'h0000, "R5 shr 32");
        // R6: signed over-range gives all sign bits
        drive(16'h8001, 16, 2'b11, 1'b1, 16'hFFFF, "R6 neg 16");
        drive(16'h8001, 255, 2'b11, 1'b1, 16'hFFFF, "R6 neg 255");
        drive(16'h7FFF, 64, 2'b11, 1'b1, 16'h0000, "R6 pos 64");
        // R8: zero amount passes through
        for (int o = 0; o < 4; o++)
            drive(16'hBEEF, 0, 2'(o), 1'b1, 16'hBEEF, "R8 zero amt");
        idle(2);
        check("R9 out_valid after gap", W'(out_valid), '0);

        // Sweep against the reference model
        begin
            int amts [12] = '{0, 1, 3, 7, 8, 15, 16, 17, 31, 48, 128, 255};
            logic [W-1:0] words [4] = '{16'h8001, 16'h7FFE, 16'hA5C3, 16'h0100};
            for (int o = 0; o < 4; o++)
                for (int sm = 0; sm < 2; sm++)
                    for (int ai = 0; ai < 12; ai++)
                        for (int wi = 0; wi < 4; wi++) begin
                            string r;
                            if (amts[ai] >= W)
                                r = (o == 3 && sm == 1) ? "R6 sweep" : "R5 sweep";
                            else if (o < 2)  r = "R1 sweep";
                            else if (o == 2) r = "R2 sweep";
                            else r = sm ? "R3 sweep" : "R4 sweep";
                            drive(words[wi], amts[ai], 2'(o), 1'(sm),
                                  model(words[wi], amts[ai], 2'(o), 1'(sm)), r);
                        end
        end
        idle(3);
        check("R9 all results delivered", W'(q.size()), '0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule